// File: doc/BRIEF.md
# Privileged CPU Control Register Unit

This block holds the architectural state of a processor core that depends on privilege. It has sixteen 32-bit general registers: eight data registers and eight address registers. The last address register is a stack pointer that maps to one of two physical registers. One is used at user level and the other at supervisor level. The block also keeps a 16-bit status word, a vector base register and two 3-bit alternate function code registers.

The execution pipeline reads two general registers at a time and writes one on each clock. System instructions reach the status word and the other control registers through a separate control port. That port checks privilege: a blocked write has no effect on the protected state and raises a fault strobe in the same cycle. Two further outputs are combinational. One tells the interrupt logic whether a pending level passes the current mask. The other gives the exception unit the vector table address for a given vector number.

Top module: `priv_state_unit`

## Requirements
- R1: General register index 0–7 selects a data register and index 8–15 selects an address register. Both read ports return the addressed register combinationally. The write port updates the register on the rising clock edge.
- R2: Index 15 selects the user stack pointer when the privilege bit is 0 and the supervisor stack pointer when it is 1. This holds for reads and writes alike.
- R3: After reset the privilege bit is 1, the mask is 7 and trace is 0. The vector base, the condition codes, both function code registers and all general registers are zero, so the status word reads 0x2700.
- R4: Status word layout: trace at bit 15, privilege at bit 13, mask at bits 10:8 and condition codes at bits 4:0. All other bits read 0 and ignore writes.
- R5: Control selects are 0 condition codes, 1 status word, 2 vector base, 3 source function code, 4 destination function code and 5 user stack pointer. At user level, selecting the status word reads only the condition codes. A write to it at user level updates only bits 4:0 and pulses the fault output. Select 0 reads and writes the condition codes at either level. No user-level access can set the privilege bit.
- R6: At user level, writes to selects 2–5 leave the target unchanged and drive the fault output high in that cycle. Reads of selects 2–5 return zero.
- R7: At supervisor level, every select is readable and writable without a fault. The function code registers keep bits 2:0, and their upper bits read zero.
- R8: A status write that changes the privilege bit changes the register that index 15 selects from the next cycle on. In the cycle of the write, index 15 still follows the old value.
- R9: The interrupt accept output is 1 when the pending level is greater than the mask, or when the level is 7.
- R10: The vector address equals the vector base plus the 8-bit vector number times 4, modulo 2^32.
- R11: Selects 6 and 7 read zero, ignore writes and never raise the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddrA | input | 4 | General register index, read port A |
| rdDataA | output | 32 | Read data, port A |
| rdAddrB | input | 4 | General register index, read port B |
| rdDataB | output | 32 | Read data, port B |
| wrEn | input | 1 | General register write enable |
| wrAddr | input | 4 | General register write index |
| wrData | input | 32 | General register write data |
| ctlEn | input | 1 | Control port access valid |
| ctlWrite | input | 1 | Control access is a write |
| ctlSel | input | 3 | Control register select |
| ctlWrData | input | 32 | Control write data |
| ctlRdData | output | 32 | Control read data |
| privFault | output | 1 | Privilege violation strobe |
| irqLevel | input | 3 | Pending interrupt level |
| irqAccept | output | 1 | Level passes the mask |
| vecNum | input | 8 | Exception vector number |
| vecAddr | output | 32 | Vector table entry address |
| supervisor | output | 1 | Current privilege bit |
| traceOn | output | 1 | Current trace bit |

## Verification
The bench builds the block with its default parameters: 32-bit registers, eight data and eight address registers, a 3-bit interrupt level and an 8-bit vector number. With a 3-bit level, every pairing of pending level and mask can be swept exhaustively. An 8-bit vector number with a vector base near the top of the address space reaches the wrap of the vector adder. Random phases use random status writes to drop into user level and periodic resets to return to supervisor level. This exercises both stack pointer mappings, the point where privilege changes, and every blocked access.

// File: rtl/priv_state_pkg.sv
package priv_state_pkg;

  typedef enum logic [2:0] {
    SEL_CCR  = 3'd0,
    SEL_SR   = 3'd1,
    SEL_VBR  = 3'd2,
    SEL_SFC  = 3'd3,
    SEL_DFC  = 3'd4,
    SEL_USP  = 3'd5,
    SEL_RSV6 = 3'd6,
    SEL_RSV7 = 3'd7
  } ctlSel_e;

  // strobes from the access control to the datapath
  typedef struct packed {
    logic wrCcr;
    logic wrSrHi;
    logic wrVbr;
    logic wrSfc;
    logic wrDfc;
    logic wrUsp;
    logic rdNarrow;
    logic rdZero;
  } ctlStrobe_t;

  localparam int SR_W        = 16;
  localparam int SR_T_BIT    = 15;
  localparam int SR_S_BIT    = 13;
  localparam int SR_MASK_LO  = 8;
  localparam int CCR_W       = 5;

endpackage

// File: rtl/priv_state_ctrl.sv
module priv_state_ctrl
  import priv_state_pkg::*;
(
  input  logic       ctlEn,
  input  logic       ctlWrite,
  input  logic [2:0] ctlSel,
  input  logic       superNow,
  output ctlStrobe_t stb,
  output logic       privFault
);

  ctlSel_e selE;
  logic    doWrite;
  logic    guarded;

  always_comb begin
    selE    = ctlSel_e'(ctlSel);
    doWrite = ctlEn && ctlWrite;
    guarded = (selE == SEL_VBR) || (selE == SEL_SFC) ||
              (selE == SEL_DFC) || (selE == SEL_USP);
  end

  always_comb begin
    stb       = '0;
    privFault = 1'b0;
    if (doWrite) begin
      unique case (selE)
        SEL_CCR: stb.wrCcr = 1'b1;
        SEL_SR: begin
          stb.wrCcr = 1'b1;
          if (superNow) stb.wrSrHi = 1'b1;
          else          privFault  = 1'b1;
        end
        SEL_VBR: if (superNow) stb.wrVbr = 1'b1; else privFault = 1'b1;
        SEL_SFC: if (superNow) stb.wrSfc = 1'b1; else privFault = 1'b1;
        SEL_DFC: if (superNow) stb.wrDfc = 1'b1; else privFault = 1'b1;
        SEL_USP: if (superNow) stb.wrUsp = 1'b1; else privFault = 1'b1;
        default: ;
      endcase
    end
    stb.rdNarrow = !superNow && (selE == SEL_SR);
    stb.rdZero   = !superNow && guarded;
  end

endmodule

// File: rtl/priv_state_dp.sv
module priv_state_dp
  import priv_state_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_DREG = 8,
  parameter int NUM_AREG = 8,
  parameter int LVL_W    = 3,
  parameter int FC_W     = 3,
  parameter int VEC_W    = 8,
  localparam int NUM_REG = NUM_DREG + NUM_AREG,
  localparam int IDX_W   = $clog2(NUM_REG)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0][IDX_W-1:0]        rdAddr,
  output logic [1:0][DATA_W-1:0]       rdData,
  input  logic                         wrEn,
  input  logic [IDX_W-1:0]             wrAddr,
  input  logic [DATA_W-1:0]            wrData,
  input  ctlStrobe_t                   stb,
  input  logic [2:0]                   ctlSel,
  input  logic [DATA_W-1:0]            ctlWrData,
  output logic [DATA_W-1:0]            ctlRdData,
  input  logic [LVL_W-1:0]             irqLevel,
  output logic                         irqAccept,
  input  logic [VEC_W-1:0]             vecNum,
  output logic [DATA_W-1:0]            vecAddr,
  output logic                         superNow,
  output logic                         traceNow
);

  localparam int SP_IDX = NUM_REG - 1;
  localparam logic [IDX_W-1:0] SP_SEL = IDX_W'(SP_IDX);

  // the user stack pointer lives in the last slot of the array
  logic [DATA_W-1:0] gpr [NUM_REG];
  logic [DATA_W-1:0] ssp;
  logic [DATA_W-1:0] vbr;
  logic [CCR_W-1:0]  ccr;
  logic [LVL_W-1:0]  mask;
  logic [FC_W-1:0]   sfc;
  logic [FC_W-1:0]   dfc;
  logic [SR_W-1:0]   srView;
  logic              spWrUser;

  assign spWrUser = wrEn && (wrAddr == SP_SEL) && !superNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REG; i++) gpr[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REG; i++) begin
        if (i == SP_IDX) begin
          if (spWrUser)        gpr[i] <= wrData;
          else if (stb.wrUsp)  gpr[i] <= ctlWrData;
        end else if (wrEn && (wrAddr == IDX_W'(i))) begin
          gpr[i] <= wrData;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ssp <= '0;
    else if (wrEn && (wrAddr == SP_SEL) && superNow) ssp <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ccr      <= '0;
      mask     <= '1;
      traceNow <= 1'b0;
      superNow <= 1'b1;
      vbr      <= '0;
      sfc      <= '0;
      dfc      <= '0;
    end else begin
      if (stb.wrCcr) ccr <= ctlWrData[CCR_W-1:0];
      if (stb.wrSrHi) begin
        traceNow <= ctlWrData[SR_T_BIT];
        superNow <= ctlWrData[SR_S_BIT];
        mask     <= ctlWrData[SR_MASK_LO +: LVL_W];
      end
      if (stb.wrVbr) vbr <= ctlWrData;
      if (stb.wrSfc) sfc <= ctlWrData[FC_W-1:0];
      if (stb.wrDfc) dfc <= ctlWrData[FC_W-1:0];
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rdPort
    always_comb begin
      if ((rdAddr[p] == SP_SEL) && superNow) rdData[p] = ssp;
      else                                   rdData[p] = gpr[rdAddr[p]];
    end
  end

  always_comb begin
    srView                         = '0;
    srView[SR_T_BIT]               = traceNow;
    srView[SR_S_BIT]               = superNow;
    srView[SR_MASK_LO +: LVL_W]    = mask;
    srView[CCR_W-1:0]              = ccr;
  end

  always_comb begin
    unique case (ctlSel_e'(ctlSel))
      SEL_CCR: ctlRdData = DATA_W'(ccr);
      SEL_SR:  ctlRdData = stb.rdNarrow ? DATA_W'(ccr) : DATA_W'(srView);
      SEL_VBR: ctlRdData = vbr;
      SEL_SFC: ctlRdData = DATA_W'(sfc);
      SEL_DFC: ctlRdData = DATA_W'(dfc);
      SEL_USP: ctlRdData = gpr[SP_IDX];
      default: ctlRdData = '0;
    endcase
    if (stb.rdZero) ctlRdData = '0;
  end

  assign irqAccept = (irqLevel > mask) || (irqLevel == '1);
  assign vecAddr   = vbr + (DATA_W'(vecNum) << 2);

endmodule

// File: rtl/priv_state_unit.sv
module priv_state_unit
  import priv_state_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_DREG = 8,
  parameter int NUM_AREG = 8,
  parameter int LVL_W    = 3,
  parameter int FC_W     = 3,
  parameter int VEC_W    = 8,
  localparam int IDX_W   = $clog2(NUM_DREG + NUM_AREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ctlEn,
  input  logic              ctlWrite,
  input  logic [2:0]        ctlSel,
  input  logic [DATA_W-1:0] ctlWrData,
  output logic [DATA_W-1:0] ctlRdData,
  output logic              privFault,
  input  logic [LVL_W-1:0]  irqLevel,
  output logic              irqAccept,
  input  logic [VEC_W-1:0]  vecNum,
  output logic [DATA_W-1:0] vecAddr,
  output logic              supervisor,
  output logic              traceOn
);

  ctlStrobe_t                stb;
  logic [1:0][IDX_W-1:0]     rdAddr;
  logic [1:0][DATA_W-1:0]    rdData;

  assign rdAddr  = {rdAddrB, rdAddrA};
  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

  priv_state_ctrl u_ctrl (
    .ctlEn     (ctlEn),
    .ctlWrite  (ctlWrite),
    .ctlSel    (ctlSel),
    .superNow  (supervisor),
    .stb       (stb),
    .privFault (privFault)
  );

  priv_state_dp #(
    .DATA_W   (DATA_W),
    .NUM_DREG (NUM_DREG),
    .NUM_AREG (NUM_AREG),
    .LVL_W    (LVL_W),
    .FC_W     (FC_W),
    .VEC_W    (VEC_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .stb       (stb),
    .ctlSel    (ctlSel),
    .ctlWrData (ctlWrData),
    .ctlRdData (ctlRdData),
    .irqLevel  (irqLevel),
    .irqAccept (irqAccept),
    .vecNum    (vecNum),
    .vecAddr   (vecAddr),
    .superNow  (supervisor),
    .traceNow  (traceOn)
  );

endmodule

// File: rtl/priv_state_chk.sv
module priv_state_chk #(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctlEn,
  input logic              ctlWrite,
  input logic [2:0]        ctlSel,
  input logic [DATA_W-1:0] ctlRdData,
  input logic              privFault,
  input logic [LVL_W-1:0]  irqLevel,
  input logic              irqAccept,
  input logic              supervisor
);

  AST_TOP_LEVEL_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel == '1) |-> irqAccept); // R9

  AST_USER_WRITE_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (ctlEn && ctlWrite && !supervisor && (ctlSel >= 3'd1) && (ctlSel <= 3'd5))
      |-> privFault); // R6

  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    privFault |-> (ctlEn && ctlWrite && !supervisor)); // R6

  AST_USER_SR_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    (!supervisor && (ctlSel == 3'd1)) |-> (ctlRdData[DATA_W-1:8] == '0)); // R5

  AST_NO_SELF_PROMOTE: assert property (@(posedge clk) disable iff (!rstN)
    !supervisor |=> !supervisor); // R5

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (ctlSel >= 3'd6) |-> (!privFault && (ctlRdData == '0))); // R11

endmodule

bind priv_state_unit priv_state_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ctlEn      (ctlEn),
  .ctlWrite   (ctlWrite),
  .ctlSel     (ctlSel),
  .ctlRdData  (ctlRdData),
  .privFault  (privFault),
  .irqLevel   (irqLevel),
  .irqAccept  (irqAccept),
  .supervisor (supervisor)
);

// File: tb/priv_state_unit_tb.sv
module priv_state_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0, ctlWrData = '0, ctlRdData, vecAddr;
  logic        wrEn = 1'b0, ctlEn = 1'b0, ctlWrite = 1'b0;
  logic [2:0]  ctlSel = '0, irqLevel = '0;
  logic [7:0]  vecNum = '0;
  logic        privFault, irqAccept, supervisor, traceOn;

  always #10 clk = ~clk;   // 50 MHz

  priv_state_unit u_dut (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ctlEn(ctlEn), .ctlWrite(ctlWrite), .ctlSel(ctlSel), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .privFault(privFault),
    .irqLevel(irqLevel), .irqAccept(irqAccept),
    .vecNum(vecNum), .vecAddr(vecAddr),
    .supervisor(supervisor), .traceOn(traceOn)
  );

  // behavioural reference state
  logic [31:0] mGpr [16];
  logic [31:0] mSsp, mVbr;
  logic [4:0]  mCcr;
  logic [2:0]  mMask, mSfc, mDfc;
  logic        mS, mT;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 16; i++) mGpr[i] = '0;
    mSsp = '0; mVbr = '0; mCcr = '0; mMask = 3'd7;
    mSfc = '0; mDfc = '0; mS = 1'b1; mT = 1'b0;
  endtask

  function automatic logic [31:0] expGpr(input logic [3:0] a);
    if (a == 4'd15 && mS) return mSsp;
    return mGpr[a];
  endfunction

  function automatic logic [31:0] expSr();
    return {16'h0, mT, 1'b0, mS, 2'b00, mMask, 3'b000, mCcr};
  endfunction

  function automatic logic [31:0] expCtl(input logic [2:0] s);
    case (s)
      3'd0: return {27'h0, mCcr};
      3'd1: return mS ? expSr() : {27'h0, mCcr};
      3'd2: return mS ? mVbr : 32'h0;
      3'd3: return mS ? {29'h0, mSfc} : 32'h0;
      3'd4: return mS ? {29'h0, mDfc} : 32'h0;
      3'd5: return mS ? mGpr[15] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string ctlTag(input logic [2:0] s);
    if (s >= 3'd6) return "R11";
    if (s <= 3'd1) return mS ? "R4" : "R5";
    return mS ? "R7" : "R6";
  endfunction

  // compare every output against the model, shortly before the rising edge
  task automatic sampleAll();
    logic expFault;
    #7;
    expFault = ctlEn && ctlWrite && !mS && (ctlSel >= 3'd1) && (ctlSel <= 3'd5);
    chk(rdAddrA == 4'd15 ? "R2" : "R1", rdDataA, expGpr(rdAddrA));
    chk(rdAddrB == 4'd15 ? "R2" : "R1", rdDataB, expGpr(rdAddrB));
    chk(ctlTag(ctlSel), ctlRdData, expCtl(ctlSel));
    chk("R6", {31'h0, privFault}, {31'h0, expFault});
    chk("R9", {31'h0, irqAccept}, {31'h0, (irqLevel > mMask) || (irqLevel == 3'd7)});
    chk("R10", vecAddr, mVbr + {22'h0, vecNum, 2'b00});
    chk("R8", {30'h0, traceOn, supervisor}, {30'h0, mT, mS});
  endtask

  // advance the model by one edge, then move to the next falling edge
  task automatic tick();
    logic nS, nT;
    logic [2:0] nMask;
    nS = mS; nT = mT; nMask = mMask;
    if (rstN) begin
      if (wrEn) begin
        if (wrAddr == 4'd15 && mS) mSsp = wrData;
        else mGpr[wrAddr] = wrData;
      end
      if (ctlEn && ctlWrite) begin
        case (ctlSel)
          3'd0: mCcr = ctlWrData[4:0];
          3'd1: begin
            mCcr = ctlWrData[4:0];
            if (mS) begin nT = ctlWrData[15]; nS = ctlWrData[13]; nMask = ctlWrData[10:8]; end
          end
          3'd2: if (mS) mVbr = ctlWrData;
          3'd3: if (mS) mSfc = ctlWrData[2:0];
          3'd4: if (mS) mDfc = ctlWrData[2:0];
          3'd5: if (mS) mGpr[15] = ctlWrData;
          default: ;
        endcase
      end
      mS = nS; mT = nT; mMask = nMask;
    end
    @(negedge clk);
  endtask

  task automatic step();
    sampleAll();
    tick();
  endtask

  task automatic idle();
    wrEn = 0; ctlEn = 0; ctlWrite = 0;
  endtask

  task automatic doReset();
    idle();
    rstN = 1'b0;
    modelReset();
    step();
    step();
    rstN = 1'b1;
  endtask

  task automatic ctlWr(input logic [2:0] s, input logic [31:0] d);
    ctlEn = 1; ctlWrite = 1; ctlSel = s; ctlWrData = d;
  endtask

  task automatic gprWr(input logic [3:0] a, input logic [31:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
  endtask

  initial begin
    modelReset();
    @(negedge clk);
    doReset();

    // R3: reset state seen at the ports
    ctlSel = 3'd1; irqLevel = 3'd6; vecNum = 8'h10;
    sampleAll();
    chk("R3", ctlRdData, 32'h0000_2700);
    chk("R3", {31'h0, supervisor}, 32'h1);
    chk("R3", {31'h0, irqAccept}, 32'h0);
    chk("R3", vecAddr, 32'h0000_0040);
    tick();

    // R1 / R2: data, address and supervisor stack pointer writes
    gprWr(4'd3, 32'h1234_5678); step();
    gprWr(4'd8, 32'hCAFE_0008); step();
    gprWr(4'd15, 32'h8000_0000); step();
    idle(); rdAddrA = 4'd3; rdAddrB = 4'd15;
    sampleAll();
    chk("R1", rdDataA, 32'h1234_5678);
    chk("R2", rdDataB, 32'h8000_0000);
    tick();

    // R4: full status write at supervisor level
    ctlWr(3'd1, 32'hFFFF_FFFF); step();
    idle(); ctlSel = 3'd1;
    sampleAll(); chk("R4", ctlRdData, 32'h0000_A71F); tick();

    // R7: function codes and user stack pointer from supervisor level
    ctlWr(3'd3, 32'hFFFF_FFFD); step();
    ctlWr(3'd5, 32'h0000_4000); step();
    idle(); ctlSel = 3'd3;
    sampleAll(); chk("R7", ctlRdData, 32'h0000_0005); tick();

    // R8: drop to user level; A7 switches only after the edge
    ctlWr(3'd1, 32'h0000_0005); rdAddrA = 4'd15;
    sampleAll(); chk("R8", rdDataA, 32'h8000_0000); tick();
    idle();
    sampleAll(); chk("R8", rdDataA, 32'h0000_4000); tick();

    // R6: blocked vector base write at user level
    ctlWr(3'd2, 32'hDEAD_0000);
    sampleAll(); chk("R6", {31'h0, privFault}, 32'h1); tick();
    idle(); vecNum = 8'h00;
    sampleAll(); chk("R6", vecAddr, 32'h0); tick();

    // R5: narrow status access at user level
    ctlWr(3'd1, 32'h0000_FFFF);
    sampleAll(); chk("R5", {31'h0, privFault}, 32'h1); tick();
    idle(); ctlSel = 3'd1;
    sampleAll();
    chk("R5", ctlRdData, 32'h0000_001F);
    chk("R5", {31'h0, supervisor}, 32'h0);
    tick();

    // R11: reserved select
    ctlWr(3'd6, 32'hFFFF_FFFF);
    sampleAll(); chk("R11", {31'h0, privFault}, 32'h0); tick();
    idle(); ctlSel = 3'd6;
    sampleAll(); chk("R11", ctlRdData, 32'h0); tick();

    // R9: every level against every mask
    doReset();
    for (int m = 0; m < 8; m++) begin
      ctlWr(3'd1, 32'h2000 | (m << 8)); step(); idle();
      for (int l = 0; l < 8; l++) begin
        irqLevel = 3'(l);
        sampleAll();
        chk("R9", {31'h0, irqAccept}, {31'h0, (l > m) || (l == 7)});
        tick();
      end
    end

    // R10: wrap of the vector adder
    ctlWr(3'd2, 32'hFFFF_FF00); step(); idle();
    vecNum = 8'hFF;
    sampleAll(); chk("R10", vecAddr, 32'h0000_02FC); tick();

    // random traffic, with resets to leave user level
    for (int c = 0; c < 6000; c++) begin
      if (c % 300 == 0) doReset();
      rdAddrA  = ($urandom % 4 == 0) ? 4'd15 : 4'($urandom);
      rdAddrB  = 4'($urandom);
      wrEn     = 1'($urandom);
      wrAddr   = ($urandom % 3 == 0) ? 4'd15 : 4'($urandom);
      wrData   = $urandom;
      ctlEn    = 1'($urandom);
      ctlWrite = 1'($urandom);
      ctlSel   = 3'($urandom);
      ctlWrData = $urandom;
      if (ctlSel == 3'd1 && ($urandom % 4 != 0)) ctlWrData[13] = 1'b1;
      irqLevel = 3'($urandom);
      vecNum   = 8'($urandom);
      step();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule